// File: doc/BRIEF.md
# Three-Region Load/Store Address Router

This block takes single load/store requests from a 32-bit processor core and steers each one to one of three targets according to its address: a tightly coupled synchronous RAM, an external-memory Wishbone master port, or a peripheral Wishbone master port. The 4 GB space is split three ways.

- The lowest 16 MB (top address byte 00h) is the internal RAM region, which holds the reset and interrupt vectors.
- The highest 16 MB (top address byte FFh) is the peripheral space.
- Everything in between goes to external memory, which serves both instruction and data traffic.

Each accepted request produces exactly one access on the selected target. The core then gets back a one-cycle completion pulse with the read data. Only one request is in flight at a time, and the core is held off with a ready-low signal until the current one completes. Both Wishbone ports are single-transfer (classic cycle) masters and tolerate any number of slave wait states. Each port also provides a copy of the system clock and reset, so its slaves can be wired to it directly.

Top module: `region_bus_router`

## Requirements
- R1: A request whose address bits 31:24 equal 00h goes only to the RAM port. One whose bits 31:24 equal FFh goes only to the peripheral port. Any other address goes only to the external port. No two targets are ever active in the same cycle.
- R2: On the external port, xm_adr carries request address bits 31:2 with bits 1:0 forced to zero. xm_sel, xm_dat_o and xm_we (0 = read, 1 = write) carry the request's byte select, write data and direction.
- R3: On the peripheral port, pm_adr carries request address bits 23:0 unchanged, and pm_sel, pm_dat_o and pm_we carry the request fields.
- R4: CYC and STB of a Wishbone port rise together in the first cycle after the request is accepted. They stay equal, and both are low in the cycle after the one in which ACK is sampled high.
- R5: While CYC is high and ACK is low, the port's address, write data, WE and SEL do not change, for any number of wait states.
- R6: rsp_done is a one-cycle pulse in the cycle after the Wishbone ACK. On a read, rsp_rdata in that cycle equals the DAT_I value presented with ACK. On a write, rsp_rdata is zero.
- R7: A RAM request raises ram_en for exactly one cycle, the first cycle after acceptance, with ram_addr = request address bits (RAM_AW+1):2 (bits 15:2 by default).
- R8: req_ready is low from the cycle after acceptance through the rsp_done cycle and is high again in the next cycle. A request presented while req_ready is low is ignored and causes no access.
- R9: During and just after reset, no CYC, STB or ram_en is active, rsp_done is low and req_ready is high. xm_rst and pm_rst follow rst, and xm_clk and pm_clk follow clk.
- R10: For a RAM request, ram_we, ram_sel and ram_wdata carry the request fields. The read data returned on rsp_rdata is the ram_rdata value present in the second cycle after acceptance. rsp_done is high in the third cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Router can accept a request |
| req_we | input | 1 | Request direction, 1 = write |
| req_addr | input | 32 | Request byte address |
| req_sel | input | 4 | Byte lane select, bit 0 = bits 7:0 |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM word address |
| ram_sel | output | 4 | RAM byte lane select |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_en |
| xm_clk | output | 1 | Clock for external-memory slaves |
| xm_rst | output | 1 | Reset for external-memory slaves |
| xm_cyc | output | 1 | External port bus cycle |
| xm_stb | output | 1 | External port strobe |
| xm_we | output | 1 | External port write enable |
| xm_adr | output | 32 | External port address, word aligned |
| xm_sel | output | 4 | External port byte select |
| xm_dat_o | output | 32 | External port write data |
| xm_dat_i | input | 32 | External port read data |
| xm_ack | input | 1 | External port acknowledge |
| pm_clk | output | 1 | Clock for peripheral slaves |
| pm_rst | output | 1 | Reset for peripheral slaves |
| pm_cyc | output | 1 | Peripheral port bus cycle |
| pm_stb | output | 1 | Peripheral port strobe |
| pm_we | output | 1 | Peripheral port write enable |
| pm_adr | output | 24 | Peripheral register address |
| pm_sel | output | 4 | Peripheral byte select |
| pm_dat_o | output | 32 | Peripheral write data |
| pm_dat_i | input | 32 | Peripheral read data |
| pm_ack | input | 1 | Peripheral acknowledge |

## Verification
A wrong region latch or a stuck busy flag shows at the ports within one or two cycles of acceptance. The symptoms are the wrong CYC or ram_en rising, two targets active at once, or req_ready failing to return the cycle after rsp_done. A corrupted holding register shows as address, SEL or data moving during a wait state, or as a mismatch against the request fields on the first active cycle. An off-by-one in the RAM sampling phase returns the garbage value the bench drives on ram_rdata outside the valid cycle. The bench mixes random addresses in all three regions with random wait counts, and it directs cases at the region boundary addresses and at requests held up while the router is busy.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int SEL_W  = DATA_W / 8;
    parameter int TAG_W  = 8;

    localparam logic [TAG_W-1:0] TAG_RAM = '0;
    localparam logic [TAG_W-1:0] TAG_PER = '1;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_EXT = 2'd1,
        RGN_PER = 2'd2
    } region_e;

    // direction, lanes and write data of one transfer
    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] wdata;
    } payload_t;

    function automatic region_e region_of(input logic [TAG_W-1:0] tag);
        if (tag == TAG_RAM)      return RGN_RAM;
        else if (tag == TAG_PER) return RGN_PER;
        else                     return RGN_EXT;
    endfunction

endpackage

// File: rtl/rbr_region_decode.sv
module rbr_region_decode
    import rbr_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    output region_e          region,
    output logic [2:0]       hit
);
    always_comb begin
        region = region_of(tag);
        hit    = 3'b000;
        hit[region] = 1'b1;
    end
endmodule

// File: rtl/rbr_wb_port.sv
module rbr_wb_port
    import rbr_pkg::*;
#(
    parameter int AW       = 32,
    parameter bit ZERO_LSB = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     req_addr,
    input  payload_t          req_pay,
    output logic              cyc,
    output logic              stb,
    output logic              we,
    output logic [AW-1:0]     adr,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dat_o,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              ack,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [AW-1:0] LSB_MASK = ZERO_LSB ? ~AW'(3) : '1;

    logic              cyc_q;
    logic [AW-1:0]     adr_q;
    payload_t          pay_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= 1'b0;
            adr_q   <= '0;
            pay_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                cyc_q <= 1'b1;
                adr_q <= req_addr & LSB_MASK;
                pay_q <= req_pay;
            end else if (cyc_q && ack) begin
                cyc_q   <= 1'b0;
                done_q  <= 1'b1;
                rdata_q <= pay_q.we ? '0 : dat_i;
            end
        end
    end

    assign cyc   = cyc_q;
    assign stb   = cyc_q;
    assign we    = pay_q.we;
    assign adr   = adr_q;
    assign sel   = pay_q.sel;
    assign dat_o = pay_q.wdata;
    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/rbr_ram_port.sv
module rbr_ram_port
    import rbr_pkg::*;
#(
    parameter int RAM_AW = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RAM_AW-1:0] req_word,
    input  payload_t          req_pay,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [SEL_W-1:0]  ram_sel,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef enum logic [1:0] {
        RP_IDLE   = 2'd0,
        RP_ISSUE  = 2'd1,
        RP_SAMPLE = 2'd2
    } rp_state_e;

    rp_state_e         st_q;
    logic [RAM_AW-1:0] word_q;
    payload_t          pay_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RP_IDLE;
            word_q  <= '0;
            pay_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                RP_IDLE: begin
                    if (start) begin
                        st_q   <= RP_ISSUE;
                        word_q <= req_word;
                        pay_q  <= req_pay;
                    end
                end
                RP_ISSUE:  st_q <= RP_SAMPLE;
                RP_SAMPLE: begin
                    st_q    <= RP_IDLE;
                    done_q  <= 1'b1;
                    rdata_q <= pay_q.we ? '0 : ram_rdata;
                end
                default:   st_q <= RP_IDLE;
            endcase
        end
    end

    assign ram_en    = (st_q == RP_ISSUE);
    assign ram_we    = pay_q.we;
    assign ram_addr  = word_q;
    assign ram_sel   = pay_q.sel;
    assign ram_wdata = pay_q.wdata;
    assign done      = done_q;
    assign rdata     = rdata_q;
endmodule

// File: rtl/region_bus_router.sv
module region_bus_router
    import rbr_pkg::*;
#(
    parameter int RAM_AW = 14,
    parameter int PER_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [SEL_W-1:0]  ram_sel,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              xm_clk,
    output logic              xm_rst,
    output logic              xm_cyc,
    output logic              xm_stb,
    output logic              xm_we,
    output logic [ADDR_W-1:0] xm_adr,
    output logic [SEL_W-1:0]  xm_sel,
    output logic [DATA_W-1:0] xm_dat_o,
    input  logic [DATA_W-1:0] xm_dat_i,
    input  logic              xm_ack,
    output logic              pm_clk,
    output logic              pm_rst,
    output logic              pm_cyc,
    output logic              pm_stb,
    output logic              pm_we,
    output logic [PER_AW-1:0] pm_adr,
    output logic [SEL_W-1:0]  pm_sel,
    output logic [DATA_W-1:0] pm_dat_o,
    input  logic [DATA_W-1:0] pm_dat_i,
    input  logic              pm_ack
);
    localparam int RAM_LO = 2;
    localparam int RAM_HI = RAM_AW + 1;

    logic              busy_q;
    region_e           rgn_q;
    region_e           rgn_now;
    logic [2:0]        hit;
    logic              accept;
    logic [2:0]        start;
    payload_t          pay;
    logic              ram_done, xm_done, pm_done;
    logic [DATA_W-1:0] ram_rd, xm_rd, pm_rd;
    logic              done_any;

    assign pay    = '{we: req_we, sel: req_sel, wdata: req_wdata};
    assign accept = req_valid && !busy_q;

    rbr_region_decode u_dec (
        .tag    (req_addr[ADDR_W-1 -: TAG_W]),
        .region (rgn_now),
        .hit    (hit)
    );

    assign start = accept ? hit : 3'b000;

    rbr_ram_port #(.RAM_AW(RAM_AW)) u_ram (
        .clk       (clk),
        .rst       (rst),
        .start     (start[RGN_RAM]),
        .req_word  (req_addr[RAM_HI:RAM_LO]),
        .req_pay   (pay),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_sel   (ram_sel),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .done      (ram_done),
        .rdata     (ram_rd)
    );

    rbr_wb_port #(.AW(ADDR_W), .ZERO_LSB(1'b1)) u_xm (
        .clk      (clk),
        .rst      (rst),
        .start    (start[RGN_EXT]),
        .req_addr (req_addr),
        .req_pay  (pay),
        .cyc      (xm_cyc),
        .stb      (xm_stb),
        .we       (xm_we),
        .adr      (xm_adr),
        .sel      (xm_sel),
        .dat_o    (xm_dat_o),
        .dat_i    (xm_dat_i),
        .ack      (xm_ack),
        .done     (xm_done),
        .rdata    (xm_rd)
    );

    rbr_wb_port #(.AW(PER_AW), .ZERO_LSB(1'b0)) u_pm (
        .clk      (clk),
        .rst      (rst),
        .start    (start[RGN_PER]),
        .req_addr (req_addr[PER_AW-1:0]),
        .req_pay  (pay),
        .cyc      (pm_cyc),
        .stb      (pm_stb),
        .we       (pm_we),
        .adr      (pm_adr),
        .sel      (pm_sel),
        .dat_o    (pm_dat_o),
        .dat_i    (pm_dat_i),
        .ack      (pm_ack),
        .done     (pm_done),
        .rdata    (pm_rd)
    );

    always_comb begin
        unique case (rgn_q)
            RGN_RAM: begin done_any = ram_done; rsp_rdata = ram_rd; end
            RGN_PER: begin done_any = pm_done;  rsp_rdata = pm_rd;  end
            default: begin done_any = xm_done;  rsp_rdata = xm_rd;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rgn_q  <= RGN_RAM;
        end else if (accept) begin
            busy_q <= 1'b1;
            rgn_q  <= rgn_now;
        end else if (done_any) begin
            busy_q <= 1'b0;
        end
    end

    assign req_ready = !busy_q;
    assign rsp_done  = done_any;

    assign xm_clk = clk;
    assign pm_clk = clk;
    assign xm_rst = rst;
    assign pm_rst = rst;
endmodule

// File: rtl/region_bus_router_chk.sv
module region_bus_router_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rsp_done,
    input logic ram_en,
    input logic xm_cyc,
    input logic xm_stb,
    input logic xm_ack,
    input logic xm_we,
    input logic [31:0] xm_adr,
    input logic [3:0]  xm_sel,
    input logic [31:0] xm_dat_o,
    input logic pm_cyc,
    input logic pm_stb,
    input logic pm_ack,
    input logic pm_we,
    input logic [23:0] pm_adr,
    input logic [3:0]  pm_sel,
    input logic [31:0] pm_dat_o
);
    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xm_cyc, pm_cyc, ram_en})); // R1
    AST_EXT_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        xm_cyc |-> (xm_adr[1:0] == 2'b00)); // R2
    AST_XM_CYC_STB_PAIR: assert property (@(posedge clk) disable iff (rst)
        xm_cyc == xm_stb); // R4
    AST_PM_CYC_STB_PAIR: assert property (@(posedge clk) disable iff (rst)
        pm_cyc == pm_stb); // R4
    AST_XM_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (xm_cyc && xm_ack) |=> !xm_cyc); // R4
    AST_PM_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (pm_cyc && pm_ack) |=> !pm_cyc); // R4
    AST_XM_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (xm_cyc && !xm_ack) |=> (xm_cyc && $stable(xm_adr) && $stable(xm_dat_o)
                                 && $stable(xm_we) && $stable(xm_sel))); // R5
    AST_PM_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (pm_cyc && !pm_ack) |=> (pm_cyc && $stable(pm_adr) && $stable(pm_dat_o)
                                 && $stable(pm_we) && $stable(pm_sel))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R6
    AST_RAM_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> !ram_en); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (xm_cyc || pm_cyc || ram_en || rsp_done) |-> !req_ready); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (!xm_cyc && !pm_cyc && !ram_en && !rsp_done && req_ready)); // R9
endmodule

bind region_bus_router region_bus_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .ram_en   (ram_en),
    .xm_cyc   (xm_cyc),
    .xm_stb   (xm_stb),
    .xm_ack   (xm_ack),
    .xm_we    (xm_we),
    .xm_adr   (xm_adr),
    .xm_sel   (xm_sel),
    .xm_dat_o (xm_dat_o),
    .pm_cyc   (pm_cyc),
    .pm_stb   (pm_stb),
    .pm_ack   (pm_ack),
    .pm_we    (pm_we),
    .pm_adr   (pm_adr),
    .pm_sel   (pm_sel),
    .pm_dat_o (pm_dat_o)
);

// File: tb/region_bus_router_test.sv
`timescale 1ns/1ps
module region_bus_router_test;
    localparam int RAM_AW = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_sel = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        ram_en, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [3:0]  ram_sel;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = 32'hBAD0BAD0;
    logic        xm_clk, xm_rst, xm_cyc, xm_stb, xm_we;
    logic [31:0] xm_adr, xm_dat_o;
    logic [3:0]  xm_sel;
    logic [31:0] xm_dat_i = '0;
    logic        xm_ack = 1'b0;
    logic        pm_clk, pm_rst, pm_cyc, pm_stb, pm_we;
    logic [23:0] pm_adr;
    logic [3:0]  pm_sel;
    logic [31:0] pm_dat_o;
    logic [31:0] pm_dat_i = '0;
    logic        pm_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    region_bus_router #(.RAM_AW(RAM_AW), .PER_AW(24)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_sel(ram_sel),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .xm_clk(xm_clk), .xm_rst(xm_rst), .xm_cyc(xm_cyc), .xm_stb(xm_stb),
        .xm_we(xm_we), .xm_adr(xm_adr), .xm_sel(xm_sel), .xm_dat_o(xm_dat_o),
        .xm_dat_i(xm_dat_i), .xm_ack(xm_ack),
        .pm_clk(pm_clk), .pm_rst(pm_rst), .pm_cyc(pm_cyc), .pm_stb(pm_stb),
        .pm_we(pm_we), .pm_adr(pm_adr), .pm_sel(pm_sel), .pm_dat_o(pm_dat_o),
        .pm_dat_i(pm_dat_i), .pm_ack(pm_ack)
    );

    // ---- expected-value helpers ----
    function automatic int exp_region(input logic [31:0] a);
        if (a[31:24] == 8'h00)      return 0;
        else if (a[31:24] == 8'hFF) return 2;
        else                        return 1;
    endfunction
    function automatic logic [31:0] ext_data(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5AC3C3;
    endfunction
    function automatic logic [31:0] per_data(input logic [23:0] a);
        return {8'hC0, a} ^ 32'h0F0F0F0F;
    endfunction
    function automatic logic [31:0] ram_data(input logic [RAM_AW-1:0] w);
        return {16'hD00D, 2'b00, w};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // one request with a slave model; junk=1 keeps req_valid high with other fields while busy
    task automatic run_req(input logic we, input logic [31:0] addr, input logic [3:0] sel,
                           input logic [31:0] wdata, input int waits, input bit junk);
        int c = 0, done_c = -1, ack_c = -10, ram_c = -10;
        int xm_seen = 0, pm_seen = 0, ram_seen = 0, wcnt = 0, rg;
        bit multi = 0, early_ready = 0, hold_bad = 0, ack_x = 0, ack_p = 0;
        logic [31:0] f_adr = '0, f_dat = '0, exp_rd;
        logic [3:0]  f_sel = '0;
        logic        f_we = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_sel = sel; req_wdata = wdata;
        @(posedge clk);
        while (done_c < 0 && c < 60) begin
            @(negedge clk);
            c++;
            if (c == 1) begin
                if (junk) begin
                    req_addr = ~addr; req_we = ~we; req_wdata = ~wdata;
                end else req_valid = 1'b0;
            end
            xm_ack = 1'b0; pm_ack = 1'b0;
            if ((32'(xm_cyc) + 32'(pm_cyc) + 32'(ram_en)) > 1) multi = 1;
            if (ack_x && xm_cyc) hold_bad = 1;
            if (ack_p && pm_cyc) hold_bad = 1;
            ack_x = 0; ack_p = 0;
            if (rsp_done) begin
                done_c = c;
                req_valid = 1'b0;
                if (req_ready) early_ready = 1;
            end else if (req_ready) early_ready = 1;
            if (xm_cyc) begin
                if (xm_stb !== 1'b1) hold_bad = 1;
                if (xm_seen == 0) begin
                    f_adr = xm_adr; f_sel = xm_sel; f_we = xm_we; f_dat = xm_dat_o;
                    chk(c == 1, "R4", "ext cyc first cycle", c, 1);
                end else if (xm_adr != f_adr || xm_sel != f_sel || xm_we != f_we || xm_dat_o != f_dat)
                    hold_bad = 1;
                xm_seen++;
                if (wcnt == waits) begin
                    xm_ack = 1'b1; xm_dat_i = ext_data(xm_adr); ack_c = c; ack_x = 1;
                end else wcnt++;
            end
            if (pm_cyc) begin
                if (pm_stb !== 1'b1) hold_bad = 1;
                if (pm_seen == 0) begin
                    f_adr = {8'h00, pm_adr}; f_sel = pm_sel; f_we = pm_we; f_dat = pm_dat_o;
                    chk(c == 1, "R4", "per cyc first cycle", c, 1);
                end else if ({8'h00, pm_adr} != f_adr || pm_sel != f_sel || pm_we != f_we || pm_dat_o != f_dat)
                    hold_bad = 1;
                pm_seen++;
                if (wcnt == waits) begin
                    pm_ack = 1'b1; pm_dat_i = per_data(pm_adr); ack_c = c; ack_p = 1;
                end else wcnt++;
            end
            if (ram_en) begin
                if (ram_seen == 0) begin
                    f_adr = 32'(ram_addr); f_sel = ram_sel; f_we = ram_we; f_dat = ram_wdata;
                    ram_c = c;
                end
                ram_seen++;
            end
            ram_rdata = (ram_seen > 0 && c == ram_c + 1) ? ram_data(f_adr[RAM_AW-1:0]) : 32'hBAD0BAD0;
        end
        xm_ack = 1'b0; pm_ack = 1'b0; req_valid = 1'b0;
        rg = exp_region(addr);
        chk(done_c > 0, "R6", "completion seen", 32'(done_c), 1);
        chk(!multi, "R1", "single target per cycle", 32'(multi), 0);
        chk(!early_ready, "R8", "ready low while busy", 32'(early_ready), 0);
        chk(!hold_bad, "R5", "fields stable and cyc==stb until ack", 32'(hold_bad), 0);
        if (rg == 0) begin
            chk(ram_seen == 1 && xm_seen == 0 && pm_seen == 0, "R1", "only RAM used",
                {ram_seen[7:0], xm_seen[7:0], pm_seen[7:0], 8'h0}, 32'h01000000);
            chk(ram_c == 1, "R7", "ram_en cycle", ram_c, 1);
            chk(f_adr[RAM_AW-1:0] == addr[RAM_AW+1:2], "R7", "ram word address", f_adr, 32'(addr[RAM_AW+1:2]));
            chk(f_we == we && f_sel == sel && f_dat == wdata, "R10", "ram fields", f_dat, wdata);
            chk(done_c == 3, "R10", "ram done cycle", done_c, 3);
            exp_rd = we ? 32'h0 : ram_data(addr[RAM_AW+1:2]);
            chk(rsp_rdata == exp_rd, "R10", "ram read data", rsp_rdata, exp_rd);
        end else begin
            if (rg == 1) begin
                chk(xm_seen > 0 && pm_seen == 0 && ram_seen == 0, "R1", "only external used",
                    {ram_seen[7:0], xm_seen[7:0], pm_seen[7:0], 8'h0}, 32'h00010000);
                chk(f_adr == {addr[31:2], 2'b00}, "R2", "ext address", f_adr, {addr[31:2], 2'b00});
                chk(f_we == we && f_sel == sel && f_dat == wdata, "R2", "ext fields", f_dat, wdata);
                exp_rd = we ? 32'h0 : ext_data({addr[31:2], 2'b00});
            end else begin
                chk(pm_seen > 0 && xm_seen == 0 && ram_seen == 0, "R1", "only peripheral used",
                    {ram_seen[7:0], xm_seen[7:0], pm_seen[7:0], 8'h0}, 32'h00000100);
                chk(f_adr[23:0] == addr[23:0], "R3", "per address", f_adr, {8'h0, addr[23:0]});
                chk(f_we == we && f_sel == sel && f_dat == wdata, "R3", "per fields", f_dat, wdata);
                exp_rd = we ? 32'h0 : per_data(addr[23:0]);
            end
            chk(wcnt == waits && (xm_seen + pm_seen) == waits + 1, "R5", "wait states honoured",
                32'(xm_seen + pm_seen), 32'(waits + 1));
            chk(done_c == ack_c + 1, "R6", "done cycle after ack", done_c, ack_c + 1);
            chk(rsp_rdata == exp_rd, "R6", "wb read data", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(!rsp_done && req_ready && !xm_cyc && !pm_cyc && !ram_en, "R8",
            "idle and ready after done", {rsp_done, req_ready, xm_cyc, pm_cyc, ram_en}, 32'b01000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(xm_rst && pm_rst, "R9", "reset outputs follow rst", {xm_rst, pm_rst}, 2'b11);
        chk(!xm_cyc && !pm_cyc && !ram_en && !rsp_done, "R9", "idle during reset",
            {xm_cyc, pm_cyc, ram_en, rsp_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !xm_cyc && !pm_cyc && !ram_en && !rsp_done, "R9", "idle after reset",
            {req_ready, xm_cyc, pm_cyc, ram_en, rsp_done}, 32'b10000);
        chk(!xm_rst && !pm_rst && xm_clk == clk && pm_clk == clk, "R9", "clock/reset copies",
            {xm_rst, pm_rst, xm_clk, pm_clk}, {2'b00, clk, clk});

        // directed region boundaries
        run_req(1'b0, 32'h00FF_FFFC, 4'hF, 32'h0, 0, 0);          // RAM top
        run_req(1'b1, 32'h0000_0000, 4'h3, 32'h1234_5678, 0, 0);  // RAM bottom write
        run_req(1'b0, 32'h0100_0000, 4'hF, 32'h0, 0, 0);          // ext bottom, zero wait
        run_req(1'b0, 32'hFEFF_FFFF, 4'h8, 32'h0, 3, 0);          // ext top, low bits cleared
        run_req(1'b1, 32'hFF00_0000, 4'h1, 32'hCAFE_F00D, 2, 0);  // per bottom write
        run_req(1'b0, 32'hFFFF_FFFF, 4'h8, 32'h0, 5, 0);          // per top, low bits kept
        // requests held while busy must be ignored
        run_req(1'b0, 32'h0000_1230, 4'hF, 32'h0, 0, 1);
        run_req(1'b1, 32'h2000_0004, 4'hC, 32'h0BAD_CAFE, 4, 1);
        run_req(1'b0, 32'hFF12_3456, 4'hF, 32'h0, 1, 1);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            int r = int'($urandom % 3);
            a = $urandom;
            if (r == 0)      a[31:24] = 8'h00;
            else if (r == 2) a[31:24] = 8'hFF;
            else             a[31:24] = 8'(1 + ($urandom % 254));
            run_req(1'($urandom), a, 4'($urandom), $urandom, int'($urandom % 5), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule